// File: doc/BRIEF.md
# Destination Address Filter Table

This block decides whether an incoming frame is addressed to this station. It keeps a small table of 48-bit station addresses, each with its own enable bit, and classifies every destination address presented to it as broadcast, table hit or reject. The classification is registered and appears one clock after the address is presented.

The table is filled by a loader. A one-cycle command pulse starts it with a descriptor count. The loader then takes 16-bit words from a ready/valid stream, which stands in for the memory fetch.

Each descriptor is four words:
- an index word, whose low bits select the entry;
- three address words, each carrying two address bytes with the lower-numbered byte in the low half.

When the count reaches zero, one further word is taken and replaces the enable mask. The busy flag then drops. Lookups use the table contents as they stand at that moment.

Top module: `cam_addr_filter`

## Requirements
- R1: After reset the loader is idle (`load_busy` and `word_ready` low), `res_valid` is low, all enable bits are clear, and any lookup other than a broadcast is rejected.
- R2: A `load_start` pulse while idle raises `load_busy` and `word_ready` on the next clock. With a count N, the loader accepts exactly 4N+1 words.
- R3: In a descriptor, only the low 4 bits of the first word pick the entry. Byte 0 of an address is the first byte on the wire (`lu_addr[47:40]`). The second word carries byte 0 in bits 7:0 and byte 1 in bits 15:8. The third word carries bytes 2 and 3 the same way, and the fourth word carries bytes 4 and 5.
- R4: The word taken after the last descriptor replaces the whole enable mask. Bit i of that word enables entry i, and an entry whose bit is clear never produces a hit.
- R5: `load_busy` drops in the cycle after the mask word is accepted. A count of zero makes the mask word the only word taken.
- R6: A lookup is a hit only when all 6 bytes equal an enabled entry. A difference in any single byte, or the same bytes in a swapped order, gives reject.
- R7: With `bcast_en` high, the all-ones address is reported as broadcast even when an enabled entry also holds it. With `bcast_en` low, the all-ones address is looked up like any other address.
- R8: `res_valid` follows `lu_valid` by exactly one clock, back-to-back lookups give back-to-back results, and a valid result has exactly one of `res_bcast`, `res_hit`, `res_reject` set.
- R9: A `load_start` pulse during a load is ignored: the running load keeps its count and finishes after its own word total.
- R10: While idle, `word_ready` is low and words offered on the stream change no entry and no enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_start | input | 1 | One-cycle command to begin a table load |
| load_count | input | CNT_W | Number of four-word descriptors in the load |
| load_busy | output | 1 | Load in progress; clears once the mask word has been taken |
| word_valid | input | 1 | Descriptor word available |
| word_data | input | 16 | Descriptor word |
| word_ready | output | 1 | Loader accepts a word this cycle |
| bcast_en | input | 1 | Accept the all-ones address as broadcast |
| lu_valid | input | 1 | Destination address valid |
| lu_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| res_valid | output | 1 | Classification valid, one clock after `lu_valid` |
| res_bcast | output | 1 | Address classified as broadcast |
| res_hit | output | 1 | Address matched an enabled entry |
| res_reject | output | 1 | Address neither broadcast nor matched |

## Verification
The bench loads entries with index words whose upper bits are set. A design that decoded the full index word would then miss the entry altogether. It probes byte-swapped and single-byte-altered copies of the loaded addresses, which catch a loader that swaps the halves of a word or a comparator that checks only part of the address. It places the all-ones address in an enabled entry and looks it up with broadcast acceptance both on and off, so a wrong priority between broadcast and table hit shows as the wrong flag. It also pulses the start command mid-load, uses a zero-count load, replaces the mask, and offers words while idle. An off-by-one count or a restartable loader then shows up as a busy flag that drops early or late, or as a change to the table.

// File: rtl/cam_addr_filter.sv
module cam_addr_filter #(
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_start,
  input  logic [CNT_W-1:0] load_count,
  output logic             load_busy,
  input  logic             word_valid,
  input  logic [15:0]      word_data,
  output logic             word_ready,
  input  logic             bcast_en,
  input  logic             lu_valid,
  input  logic [47:0]      lu_addr,
  output logic             res_valid,
  output logic             res_bcast,
  output logic             res_hit,
  output logic             res_reject
);
  localparam int IDX_W = $clog2(ENTRIES);

  typedef enum logic [2:0] {S_IDLE, S_IDX, S_W1, S_W2, S_W3, S_MASK} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [31:0]      stage;
  logic [ENTRIES-1:0] en_q;
  logic [ENTRIES-1:0] match;

  wire        take    = word_valid && word_ready;
  wire [15:0] swapped = {word_data[7:0], word_data[15:8]};

  assign load_busy  = (st != S_IDLE);
  assign word_ready = load_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      stage <= '0;
      en_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (load_start) begin
          cnt <= load_count;
          st  <= (load_count == '0) ? S_MASK : S_IDX;
        end
        S_IDX: if (take) begin
          idx <= word_data[IDX_W-1:0];
          st  <= S_W1;
        end
        S_W1: if (take) begin
          stage[31:16] <= swapped;
          st <= S_W2;
        end
        S_W2: if (take) begin
          stage[15:0] <= swapped;
          st <= S_W3;
        end
        S_W3: if (take) begin
          cnt <= cnt - 1'b1;
          st  <= (cnt == 1) ? S_MASK : S_IDX;
        end
        S_MASK: if (take) begin
          en_q <= word_data[ENTRIES-1:0];
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [47:0] ent;
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent <= '0;
      else if (st == S_W3 && take && idx == IDX_W'(i))
        ent <= {stage, swapped};
    end
    assign match[i] = en_q[i] && (ent == lu_addr);
  end

  wire is_bc  = bcast_en && (&lu_addr);
  wire any_hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_bcast  <= 1'b0;
      res_hit    <= 1'b0;
      res_reject <= 1'b0;
    end else begin
      res_valid  <= lu_valid;
      res_bcast  <= lu_valid && is_bc;
      res_hit    <= lu_valid && !is_bc && any_hit;
      res_reject <= lu_valid && !is_bc && !any_hit;
    end
  end
endmodule

// File: rtl/cam_addr_filter_chk.sv
module cam_addr_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        load_start,
  input logic        load_busy,
  input logic        word_valid,
  input logic        word_ready,
  input logic        bcast_en,
  input logic        lu_valid,
  input logic [47:0] lu_addr,
  input logic        res_valid,
  input logic        res_bcast,
  input logic        res_hit,
  input logic        res_reject
);
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) lu_valid |=> res_valid); // R8
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n) !lu_valid |=> !res_valid); // R8
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> $countones({res_bcast, res_hit, res_reject}) == 1); // R8
  AST_BCAST_WINS: assert property (@(posedge clk) disable iff (!rst_n) (lu_valid && bcast_en && (&lu_addr)) |=> res_bcast); // R7
  AST_NO_BCAST_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) (lu_valid && !bcast_en) |=> !res_bcast); // R7
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(load_busy) |-> $past(load_start)); // R2
  AST_DONE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n) $fell(load_busy) |-> $past(word_valid && word_ready)); // R5
  AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) !load_busy |-> !word_ready); // R10
endmodule

bind cam_addr_filter cam_addr_filter_chk i_chk (
  .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_busy(load_busy),
  .word_valid(word_valid), .word_ready(word_ready), .bcast_en(bcast_en),
  .lu_valid(lu_valid), .lu_addr(lu_addr), .res_valid(res_valid),
  .res_bcast(res_bcast), .res_hit(res_hit), .res_reject(res_reject)
);

// File: tb/test_cam_addr_filter.sv
module test_cam_addr_filter;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] E_BC = 3'b100, E_HIT = 3'b010, E_REJ = 3'b001;

  logic clk = 0, rst_n = 0, load_start = 0, word_valid = 0, bcast_en = 0, lu_valid = 0;
  logic [4:0]  load_count = 0;
  logic [15:0] word_data = 0;
  logic [47:0] lu_addr = 0;
  logic load_busy, word_ready, res_valid, res_bcast, res_hit, res_reject;

  int checks = 0, errors = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  cam_addr_filter i_cam_addr_filter (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_count(load_count),
    .load_busy(load_busy), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .bcast_en(bcast_en), .lu_valid(lu_valid),
    .lu_addr(lu_addr), .res_valid(res_valid), .res_bcast(res_bcast),
    .res_hit(res_hit), .res_reject(res_reject));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) check("R8 unexpected result", 1, 0);
      else begin
        automatic logic [2:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, {res_bcast, res_hit, res_reject}, e);
      end
    end
  end

  task automatic lookup(input logic [47:0] a, input logic [2:0] e, input string t);
    @(posedge clk); #1;
    lu_valid = 1; lu_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    lu_valid = 0;
  endtask

  task automatic lookup2(input logic [47:0] a, input logic [2:0] ea,
                         input logic [47:0] b, input logic [2:0] eb);
    @(posedge clk); #1;
    lu_valid = 1; lu_addr = a; exp_q.push_back(ea); tag_q.push_back("R8 back-to-back first");
    @(posedge clk); #1;
    lu_addr = b; exp_q.push_back(eb); tag_q.push_back("R8 back-to-back second");
    @(posedge clk); #1;
    lu_valid = 0;
  endtask

  task automatic drain;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 all results seen", exp_q.size(), 0);
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    while (!word_ready) @(negedge clk);
    word_valid = 1; word_data = w;
    @(posedge clk); #1;
    word_valid = 0;
  endtask

  task automatic start(input logic [4:0] n);
    @(posedge clk); #1;
    load_start = 1; load_count = n;
    @(posedge clk); #1;
    load_start = 0;
  endtask

  task automatic send_desc(input logic [15:0] idxw, input logic [47:0] a);
    send(idxw);
    send({a[39:32], a[47:40]});
    send({a[23:16], a[31:24]});
    send({a[7:0], a[15:8]});
  endtask

  localparam logic [47:0] ADDR_A = 48'h02_60_8C_12_34_56;
  localparam logic [47:0] ADDR_B = 48'hAA_BB_CC_DD_EE_01;
  localparam logic [47:0] ADDR_C = 48'h10_20_30_40_50_60;
  localparam logic [47:0] ONES   = 48'hFFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    check("R1 busy after reset", load_busy, 0);
    check("R1 ready after reset", word_ready, 0);
    check("R1 res_valid after reset", res_valid, 0);
    lookup(48'h00_11_22_33_44_55, E_REJ, "R1 reject after reset");
    lookup(ONES, E_REJ, "R1 all-ones without broadcast");

    start(3);
    @(negedge clk);
    check("R2 busy after start", load_busy, 1);
    check("R2 ready after start", word_ready, 1);
    send_desc(16'hFFF2, ADDR_A);
    @(posedge clk); #1; load_start = 1; load_count = 1;
    @(posedge clk); #1; load_start = 0;
    send_desc(16'h0015, ADDR_B);
    send_desc(16'h000F, ADDR_C);
    @(negedge clk);
    check("R9 still busy after 3 descriptors despite restart", load_busy, 1);
    send(16'h0024);
    @(negedge clk);
    check("R5 busy clears after mask", load_busy, 0);

    lookup(ADDR_A, E_HIT, "R3 entry 2 via high-bit index");
    lookup(ADDR_B, E_HIT, "R3 entry 5 via index 0x15");
    lookup(ADDR_C, E_REJ, "R4 disabled entry 15");
    lookup(48'h02_60_8C_12_34_57, E_REJ, "R6 last byte differs");
    lookup(48'h60_02_12_8C_56_34, E_REJ, "R6 byte-swapped address");
    lookup(48'h03_60_8C_12_34_56, E_REJ, "R6 first byte differs");
    lookup2(ADDR_B, E_HIT, ADDR_C, E_REJ);
    drain();

    start(1);
    send_desc(16'h0000, ONES);
    send(16'h0001);
    @(negedge clk);
    check("R5 busy clears after single descriptor", load_busy, 0);
    bcast_en = 0;
    lookup(ONES, E_HIT, "R7 all-ones from table when broadcast off");
    bcast_en = 1;
    lookup(ONES, E_BC, "R7 broadcast wins over table");
    lookup(ADDR_A, E_REJ, "R4 mask replaced, entry 2 off");
    bcast_en = 0;
    drain();

    start(0);
    @(negedge clk);
    check("R5 zero-count busy", load_busy, 1);
    send(16'h0024);
    @(negedge clk);
    check("R5 zero-count done after one word", load_busy, 0);
    lookup(ADDR_A, E_HIT, "R4 mask-only reload enables entry 2");

    @(posedge clk); #1;
    word_valid = 1; word_data = 16'h0000;
    @(negedge clk);
    check("R10 ready low when idle", word_ready, 0);
    repeat (4) @(posedge clk);
    #1 word_valid = 0;
    lookup(ADDR_A, E_HIT, "R10 idle words leave entry 2");
    lookup(ADDR_B, E_HIT, "R10 idle words leave mask");
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule